// File: doc/BRIEF.md
# Five-Stage Twisted-Ring Decade Counter

This block counts clock events modulo ten using a five-flop twisted ring. On every enabled clock the flops shift one place toward the last stage, and the first stage takes the inverse of the last. Starting from all zeros, ones fill the ring one stage at a time until it is full. Zeros then fill it the same way, so the ring passes through ten distinct patterns before it repeats.

A decoder turns each legal pattern into one of ten one-hot state lines. Each line is found by testing two neighbouring stages. A carry line is high for the first half of the cycle, which gives a divide-by-ten square wave with a 50 % duty cycle.

Five flops can hold 32 patterns, and 22 of them are not on the cycle. If the ring ever holds one of them, for example through a power-up value, the first enabled clock sends it to state 0. The state lines and the carry are registered. They change on the same edge that moves the ring.

Top module: `johnson_decade`

## Requirements
- R1: When `rst` is high at a rising edge, the block enters state 0 whatever `en` is. After that edge `state_sel` is 10'b0000000001 and `carry_out` is 1.
- R2: In legal state k (0 to 9), only bit k of `state_sel` is high. While the ring holds one of the 22 illegal patterns, all bits of `state_sel` are low.
- R3: A rising edge with `en` high and `rst` low moves the block from state k to state (k+1) mod 10, so state 9 wraps to state 0. The outputs show the new state right after that edge.
- R4: A rising edge with `en` low and `rst` low leaves `state_sel` and `carry_out` unchanged.
- R5: `carry_out` is 1 in states 0 to 4 and 0 in states 5 to 9. It is also 0 while the ring holds an illegal pattern.
- R6: If the ring holds an illegal pattern, the first rising edge with `en` high puts it in state 0. Counting then goes on normally from state 0.
- R7: A rising edge with `en` low leaves an illegal pattern in place, so `state_sel` stays all low and `carry_out` stays 0.
- R8: With the default power-up value (all stages zero), the outputs read as state 0 before the first clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the block acts on the rising edge |
| rst | input | 1 | Synchronous reset to state 0, active high, takes priority over `en` |
| en | input | 1 | Count enable, active high |
| state_sel | output | 10 | One-hot decoded state; bit k is high in state k |
| carry_out | output | 1 | High in states 0 to 4 |

## Verification
Two of this block's functions can fall on the same clock edge.

The first pair is reset and counting. The bench raises `rst` with `en` high, and again with `en` low, both in the middle of a cycle. It expects state 0 after either edge, never the next state of the count.

The second pair is illegal-pattern recovery and the enable. A second instance powers up with an illegal pattern. The bench first clocks it with `en` low and expects the all-low outputs to stay all low. It then gives one enabled edge and expects state 0, followed by a normal count.

// File: rtl/johnson_pkg.sv
package johnson_pkg;

  // Returns 1 when a ring pattern of n stages has at most one boundary
  // between adjacent stages that hold different values.
  function automatic logic ring_legal(input logic [31:0] v, input int n);
    int edges;
    edges = 0;
    for (int i = 0; i < n - 1; i++) begin
      if (v[i] != v[i+1]) edges++;
    end
    return (edges <= 1);
  endfunction

  // Maps a ring pattern of n stages to its one-hot state vector.
  // Bit k of the result is state k. An illegal pattern maps to zero.
  function automatic logic [63:0] ring_decode(input logic [31:0] v, input int n);
    logic [63:0] r;
    r = '0;
    if (ring_legal(v, n)) begin
      for (int k = 0; k < 2 * n; k++) begin
        if (k == 0)      r[k] = ~v[0] & ~v[n-1];
        else if (k < n)  r[k] = v[k-1] & ~v[k];
        else if (k == n) r[k] = v[0] & v[n-1];
        else             r[k] = ~v[k-n-1] & v[k-n];
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/johnson_legal.sv
module johnson_legal #(
  parameter int STAGES = 5
) (
  input  logic [STAGES-1:0] ring,
  output logic              ok
);
  localparam int NBOUND = STAGES - 1;

  logic [NBOUND-1:0] boundary;

  // One bit for each pair of neighbouring stages that differ.
  genvar i;
  generate
    for (i = 0; i < NBOUND; i++) begin : g_bound
      assign boundary[i] = ring[i] ^ ring[i+1];
    end
  endgenerate

  // A legal ring pattern has no such boundary, or exactly one.
  assign ok = ($countones(boundary) <= 1);
endmodule

// File: rtl/johnson_next.sv
module johnson_next #(
  parameter int STAGES = 5
) (
  input  logic [STAGES-1:0] cur,
  input  logic              rst,
  input  logic              en,
  output logic [STAGES-1:0] nxt
);
  logic cur_ok;

  johnson_legal #(.STAGES(STAGES)) u_legal (
    .ring (cur),
    .ok   (cur_ok)
  );

  // Priority: reset, then hold, then recovery from an illegal pattern,
  // then the twisted shift.
  always_comb begin
    if (rst)          nxt = '0;
    else if (!en)     nxt = cur;
    else if (!cur_ok) nxt = '0;
    else              nxt = {cur[STAGES-2:0], ~cur[STAGES-1]};
  end
endmodule

// File: rtl/johnson_decode.sv
module johnson_decode #(
  parameter int STAGES = 5
) (
  input  logic [STAGES-1:0]   ring,
  output logic [2*STAGES-1:0] sel,
  output logic                carry
);
  localparam int NSTATE = 2 * STAGES;

  logic              ring_ok;
  logic [NSTATE-1:0] raw;

  johnson_legal #(.STAGES(STAGES)) u_legal (
    .ring (ring),
    .ok   (ring_ok)
  );

  // Each state is found by testing one pair of neighbouring stages.
  // States 0 and STAGES use the pair made of the first and last stages.
  genvar k;
  generate
    for (k = 0; k < NSTATE; k++) begin : g_state
      if (k == 0) begin : g_empty
        assign raw[k] = ~ring[0] & ~ring[STAGES-1];
      end else if (k < STAGES) begin : g_fill
        assign raw[k] = ring[k-1] & ~ring[k];
      end else if (k == STAGES) begin : g_full
        assign raw[k] = ring[0] & ring[STAGES-1];
      end else begin : g_drain
        assign raw[k] = ~ring[k-STAGES-1] & ring[k-STAGES];
      end
    end
  endgenerate

  // An illegal pattern could make several pair tests true, so gate them all.
  assign sel   = ring_ok ? raw : '0;
  assign carry = ring_ok & ~ring[STAGES-1];
endmodule

// File: rtl/johnson_decade.sv
module johnson_decade #(
  parameter int                STAGES     = 5,
  parameter logic [STAGES-1:0] INIT_STATE = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  output logic [2*STAGES-1:0]  state_sel,
  output logic                 carry_out
);
  localparam int          NSTATE     = 2 * STAGES;
  localparam logic [63:0] INIT_DEC   = johnson_pkg::ring_decode(32'(INIT_STATE), STAGES);
  localparam logic        INIT_CARRY = johnson_pkg::ring_legal(32'(INIT_STATE), STAGES)
                                       & ~INIT_STATE[STAGES-1];

  logic [STAGES-1:0] ring_q = INIT_STATE;
  logic [STAGES-1:0] ring_d;
  logic [NSTATE-1:0] sel_q  = INIT_DEC[NSTATE-1:0];
  logic [NSTATE-1:0] sel_d;
  logic              carry_q = INIT_CARRY;
  logic              carry_d;

  johnson_next #(.STAGES(STAGES)) u_next (
    .cur (ring_q),
    .rst (rst),
    .en  (en),
    .nxt (ring_d)
  );

  // The decoder works on the next pattern, so the output registers change
  // on the same edge as the ring.
  johnson_decode #(.STAGES(STAGES)) u_dec (
    .ring  (ring_d),
    .sel   (sel_d),
    .carry (carry_d)
  );

  always_ff @(posedge clk) begin
    ring_q  <= ring_d;
    sel_q   <= sel_d;
    carry_q <= carry_d;
  end

  assign state_sel = sel_q;
  assign carry_out = carry_q;
endmodule

// File: rtl/johnson_decade_chk.sv
module johnson_decade_chk #(
  parameter int STAGES = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                en,
  input logic [2*STAGES-1:0] state_sel,
  input logic                carry_out
);
  localparam int                NSTATE = 2 * STAGES;
  localparam logic [NSTATE-1:0] FIRST  = NSTATE'(1);

  // R2: never more than one state line high
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(state_sel));

  // R3: an enabled edge rotates the one-hot state by one place
  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    (en && (|state_sel)) |=>
      (state_sel == {$past(state_sel[NSTATE-2:0]), $past(state_sel[NSTATE-1])}));

  // R4: a disabled edge changes nothing
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(state_sel) && $stable(carry_out)));

  // R1: reset lands in state 0
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (state_sel == FIRST && carry_out));

  // R5: carry agrees with the lower half of the decoded states
  a_r5_carry: assert property (@(posedge clk) disable iff (rst)
    carry_out == (|state_sel[STAGES-1:0]));

  // R6: an illegal pattern goes to state 0 on an enabled edge
  a_r6_recover: assert property (@(posedge clk) disable iff (rst)
    (en && state_sel == '0) |=> (state_sel == FIRST));
endmodule

bind johnson_decade johnson_decade_chk #(.STAGES(STAGES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .state_sel (state_sel),
  .carry_out (carry_out)
);

// File: tb/johnson_decade_test.sv
`timescale 1ns/1ps
module johnson_decade_test;
  localparam int NS = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic en_b = 1'b0;
  logic rst_b = 1'b0;
  logic [NS-1:0] sel, sel_b;
  logic carry, carry_b;
  int checks = 0;
  int fails = 0;
  int idx = 0;

  always #10 clk = ~clk;

  johnson_decade uut (
    .clk(clk), .rst(rst), .en(en), .state_sel(sel), .carry_out(carry)
  );

  // Second instance powered up holding an illegal pattern.
  johnson_decade #(.STAGES(5), .INIT_STATE(5'b01010)) uut_odd (
    .clk(clk), .rst(rst_b), .en(en_b), .state_sel(sel_b), .carry_out(carry_b)
  );

  task automatic check(input string req, input logic [NS-1:0] s, input logic c,
                       input logic [NS-1:0] es, input logic ec);
    checks++;
    if (s !== es || c !== ec) begin
      fails++;
      $display("FAIL %s sel=%b carry=%b expected sel=%b carry=%b", req, s, c, es, ec);
    end
  endtask

  function automatic logic [NS-1:0] exp_sel(input int k);
    return NS'(1) << k;
  endfunction

  function automatic logic exp_carry(input int k);
    return (k < 5);
  endfunction

  // Let one rising edge pass; sample and drive at the falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_powerup();
    #5;
    check("R8 powerup", sel, carry, exp_sel(0), 1'b1);
    check("R2 illegal powerup", sel_b, carry_b, '0, 1'b0);
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b0;
    tick();
    idx = 0;
    check("R1 reset", sel, carry, exp_sel(0), 1'b1);
  endtask

  task automatic t_count();
    rst = 1'b0; en = 1'b1;
    for (int i = 1; i <= 23; i++) begin
      tick();
      idx = (idx + 1) % 10;
      check("R3 R5 count", sel, carry, exp_sel(idx), exp_carry(idx));
    end
  endtask

  task automatic t_hold();
    en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R4 hold", sel, carry, exp_sel(idx), exp_carry(idx));
    end
    en = 1'b1;
    tick();
    idx = (idx + 1) % 10;
    check("R3 resume", sel, carry, exp_sel(idx), exp_carry(idx));
    // toggle enable every other edge
    for (int i = 0; i < 8; i++) begin
      en = i[0];
      tick();
      if (en) idx = (idx + 1) % 10;
      check("R4 R2 gated", sel, carry, exp_sel(idx), exp_carry(idx));
    end
  endtask

  task automatic t_reset_priority();
    en = 1'b1;
    while (idx != 7) begin
      tick();
      idx = (idx + 1) % 10;
    end
    check("R5 state7", sel, carry, exp_sel(7), 1'b0);
    rst = 1'b1;
    tick();
    idx = 0;
    check("R1 reset with enable", sel, carry, exp_sel(0), 1'b1);
    rst = 1'b0;
    for (int i = 0; i < 5; i++) tick();
    idx = 5;
    check("R5 state5", sel, carry, exp_sel(5), 1'b0);
    rst = 1'b1; en = 1'b0;
    tick();
    idx = 0;
    check("R1 reset without enable", sel, carry, exp_sel(0), 1'b1);
    rst = 1'b0;
  endtask

  task automatic t_recover();
    en_b = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R7 illegal held", sel_b, carry_b, '0, 1'b0);
    end
    en_b = 1'b1;
    tick();
    check("R6 recovery", sel_b, carry_b, exp_sel(0), 1'b1);
    for (int i = 1; i <= 6; i++) begin
      tick();
      check("R6 count after recovery", sel_b, carry_b, exp_sel(i), exp_carry(i));
    end
    en_b = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_powerup();
    @(negedge clk);
    t_reset();
    t_count();
    t_hold();
    t_reset_priority();
    t_recover();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule